// File: doc/BRIEF.md
# Receive Sampling Phase Tuner

This block searches for a reliable receive sampling phase on a memory-card host interface. On a start pulse it steps a 5-bit phase code upward from 0 to 31. At each step it updates the phase field of the host's control register with a read-modify-write, waits a settle interval and clears the raw interrupt status. It then asks an external tuning-command engine for one pass/fail trial.

The first passing phase opens a window. The first failure after that closes it, one step below the failing phase. If no failure comes before the top code, the window closes at 31. The block then programs the truncated midpoint of the window, waits, clears the interrupt status again and reports done. If no phase passes, it programs phase 0 and reports done with the error flag set. The chosen phase stays visible on a status output.

Top module: `phase_tune_ctrl`

## Requirements
- R1: After reset, busy, done and error are low, the status phase is 0, and neither a register request nor a trial request is active.
- R2: Phases are tried in rising order from 0. Each setting reads the control register (reg_sel_o=0) and writes it back with bits 20:16 replaced by the phase and every other bit equal to the value read.
- R3: After every control-register write, no further register access starts for at least SETTLE_CYCLES clock cycles.
- R4: Before every trial, the block writes 0x1FFFF to the interrupt-status register (reg_sel_o=1). The trial request is a single-cycle pulse issued after that write completes.
- R5: The first passing phase starts the window. After that, the first failing trial ends the sweep immediately, and the window end is the failing phase minus one.
- R6: When a window has started and no failure occurs up to phase 31, the window end is 31.
- R7: On success the block writes floor((start+end)/2) into the phase field, then clears the interrupt status. Only then does it raise done with error low and show that phase on phase_o.
- R8: When no trial passes, the block writes phase 0, waits the settle interval and clears the interrupt status. It then raises done with error high and phase_o equal to 0.
- R9: Done, error and phase_o hold their values until the next accepted start. A start pulse that arrives while busy is ignored.
- R10: Busy rises in the cycle after an accepted start and falls in the same cycle that done rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| busy_o | output | 1 | Tuning in progress |
| done_o | output | 1 | Tuning finished, held until next start |
| error_o | output | 1 | No passing phase was found |
| phase_o | output | PHASE_W | Chosen phase |
| reg_req_o | output | 1 | Register access request, held until acknowledged |
| reg_we_o | output | 1 | 1 = write, 0 = read |
| reg_sel_o | output | 1 | 0 = control register, 1 = interrupt status |
| reg_wdata_o | output | DATA_W | Write data |
| reg_rdata_i | input | DATA_W | Read data, valid with acknowledge |
| reg_ack_i | input | 1 | Access complete |
| trial_req_o | output | 1 | One-cycle trial request |
| trial_done_i | input | 1 | Trial result strobe |
| trial_pass_i | input | 1 | Trial outcome, valid with trial_done_i |

## Verification
The hardest cases to reach are the ones that decide where the window closes. These are a pass at phase 31 that opens and closes the window in the same step, an all-pass sweep, and a second passing region after a gap. A second region must never widen the result. The bench reaches them by loading a 32-bit pass map into its trial responder, which answers each trial from the phase currently held in its control-register model. Maps covering each of these shapes give expected event sequences and results that differ, and a scoreboard compares them step by step. A start pulse is also injected in the middle of a sweep to show that it leaves the sequence unchanged.

// File: rtl/phase_tune_pkg.sv
package phase_tune_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_SETTLE,
        ST_CLEAR,
        ST_TRIAL,
        ST_WAIT,
        ST_PICK
    } tune_state_e;
endpackage

// File: rtl/pt_settle_timer.sv
module pt_settle_timer #(
    parameter int unsigned CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expired_o
);
    localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    assign expired_o = t_q.run && (t_q.cnt == '0);

    always_comb begin
        t_d = t_q;
        if (load_i) begin
            t_d.run = 1'b1;
            t_d.cnt = CW'(CYCLES - 1);
        end else if (expired_o) begin
            t_d.run = 1'b0;
        end else if (t_q.run) begin
            t_d.cnt = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end
endmodule

// File: rtl/pt_field_insert.sv
module pt_field_insert #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned FIELD_W = 5,
    parameter int unsigned LSB     = 16
) (
    input  logic [DATA_W-1:0]  word_i,
    input  logic [FIELD_W-1:0] field_i,
    output logic [DATA_W-1:0]  word_o
);
    localparam logic [DATA_W-1:0] MASK = ((DATA_W'(1) << FIELD_W) - 1) << LSB;

    assign word_o = (word_i & ~MASK) | (DATA_W'(field_i) << LSB);
endmodule

// File: rtl/pt_window_mid.sv
module pt_window_mid #(
    parameter int unsigned PHASE_W = 5
) (
    input  logic               valid_i,
    input  logic [PHASE_W-1:0] lo_i,
    input  logic [PHASE_W-1:0] hi_i,
    output logic [PHASE_W-1:0] mid_o
);
    logic [PHASE_W:0] sum;

    assign sum   = {1'b0, lo_i} + {1'b0, hi_i};
    assign mid_o = valid_i ? sum[PHASE_W:1] : '0;
endmodule

// File: rtl/phase_tune_ctrl.sv
module phase_tune_ctrl
    import phase_tune_pkg::*;
#(
    parameter int unsigned DATA_W        = 32,
    parameter int unsigned PHASE_W       = 5,
    parameter int unsigned PHASE_LSB     = 16,
    parameter int unsigned CLR_W         = 17,
    parameter int unsigned SETTLE_CYCLES = 100000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               error_o,
    output logic [PHASE_W-1:0] phase_o,
    output logic               reg_req_o,
    output logic               reg_we_o,
    output logic               reg_sel_o,
    output logic [DATA_W-1:0]  reg_wdata_o,
    input  logic [DATA_W-1:0]  reg_rdata_i,
    input  logic               reg_ack_i,
    output logic               trial_req_o,
    input  logic               trial_done_i,
    input  logic               trial_pass_i
);
    localparam logic [PHASE_W-1:0] PHASE_TOP = '1;
    localparam logic [DATA_W-1:0]  CLR_VALUE = (DATA_W'(1) << CLR_W) - 1;

    typedef struct packed {
        tune_state_e        st;
        logic [PHASE_W-1:0] phase;
        logic [DATA_W-1:0]  shadow;
        logic               have;
        logic [PHASE_W-1:0] win_lo;
        logic [PHASE_W-1:0] win_hi;
        logic               last_pass;
        logic               done;
        logic               err;
        logic [PHASE_W-1:0] result;
    } ctl_t;

    ctl_t r_d, r_q;

    logic               settle_load;
    logic               settle_done;
    logic [DATA_W-1:0]  merged_word;
    logic [PHASE_W-1:0] mid_phase;

    pt_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_settle (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (settle_load),
        .expired_o (settle_done)
    );

    pt_field_insert #(.DATA_W(DATA_W), .FIELD_W(PHASE_W), .LSB(PHASE_LSB)) u_insert (
        .word_i  (r_q.shadow),
        .field_i (r_q.phase),
        .word_o  (merged_word)
    );

    pt_window_mid #(.PHASE_W(PHASE_W)) u_mid (
        .valid_i (r_q.have),
        .lo_i    (r_q.win_lo),
        .hi_i    (r_q.win_hi),
        .mid_o   (mid_phase)
    );

    always_comb begin
        r_d         = r_q;
        reg_req_o   = 1'b0;
        reg_we_o    = 1'b0;
        reg_sel_o   = 1'b0;
        reg_wdata_o = '0;
        trial_req_o = 1'b0;
        settle_load = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st        = ST_READ;
                    r_d.phase     = '0;
                    r_d.have      = 1'b0;
                    r_d.win_lo    = '0;
                    r_d.win_hi    = '0;
                    r_d.last_pass = 1'b0;
                    r_d.done      = 1'b0;
                    r_d.err       = 1'b0;
                end
            end
            ST_READ: begin
                reg_req_o = 1'b1;
                if (reg_ack_i) begin
                    r_d.shadow = reg_rdata_i;
                    r_d.st     = ST_WRITE;
                end
            end
            ST_WRITE: begin
                reg_req_o   = 1'b1;
                reg_we_o    = 1'b1;
                reg_wdata_o = merged_word;
                if (reg_ack_i) begin
                    settle_load = 1'b1;
                    r_d.st      = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (settle_done) r_d.st = ST_CLEAR;
            end
            ST_CLEAR: begin
                reg_req_o   = 1'b1;
                reg_we_o    = 1'b1;
                reg_sel_o   = 1'b1;
                reg_wdata_o = CLR_VALUE;
                if (reg_ack_i) begin
                    if (r_q.last_pass) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st = ST_TRIAL;
                    end
                end
            end
            ST_TRIAL: begin
                trial_req_o = 1'b1;
                r_d.st      = ST_WAIT;
            end
            ST_WAIT: begin
                if (trial_done_i) begin
                    if (trial_pass_i && !r_q.have) begin
                        r_d.have   = 1'b1;
                        r_d.win_lo = r_q.phase;
                        if (r_q.phase == PHASE_TOP) begin
                            r_d.win_hi = PHASE_TOP;
                            r_d.st     = ST_PICK;
                        end else begin
                            r_d.phase = r_q.phase + 1'b1;
                            r_d.st    = ST_READ;
                        end
                    end else if (!trial_pass_i && r_q.have) begin
                        r_d.win_hi = r_q.phase - 1'b1;
                        r_d.st     = ST_PICK;
                    end else if (r_q.phase == PHASE_TOP) begin
                        r_d.win_hi = PHASE_TOP;
                        r_d.st     = ST_PICK;
                    end else begin
                        r_d.phase = r_q.phase + 1'b1;
                        r_d.st    = ST_READ;
                    end
                end
            end
            ST_PICK: begin
                r_d.phase     = mid_phase;
                r_d.result    = mid_phase;
                r_d.err       = !r_q.have;
                r_d.last_pass = 1'b1;
                r_d.st        = ST_READ;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy_o  = (r_q.st != ST_IDLE);
    assign done_o  = r_q.done;
    assign error_o = r_q.err;
    assign phase_o = r_q.result;

    // cycles since the last control-register write completed (saturating)
    localparam int unsigned GW = $clog2(SETTLE_CYCLES + 2);
    logic [GW-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (reg_req_o && reg_we_o && !reg_sel_o && reg_ack_i) begin
            gap_q <= '0;
        end else if (gap_q < GW'(SETTLE_CYCLES)) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    assert_settle_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req_o && reg_sel_o && !$past(reg_req_o)) |-> (gap_q >= GW'(SETTLE_CYCLES)));

    assert_trial_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trial_req_o |=> !trial_req_o);

    assert_clear_before_trial_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trial_req_o |-> $past(reg_req_o && reg_sel_o && reg_ack_i));

    assert_trial_no_reg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trial_req_o |-> !reg_req_o);

    assert_err_phase_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |-> (phase_o == '0));

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(error_o) && $stable(phase_o)));

    assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
endmodule

// File: tb/phase_tune_ctrl_tb_top.sv
module phase_tune_ctrl_tb_top;
    localparam int SETTLE = 8;
    localparam int TRIAL_LAT = 3;
    localparam logic [31:0] CTRL_INIT = 32'hC35A_9E17;
    localparam logic [31:0] FIELD_MASK = 32'h001F_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        busy_o, done_o, error_o;
    logic [4:0]  phase_o;
    logic        reg_req_o, reg_we_o, reg_sel_o;
    logic [31:0] reg_wdata_o;
    logic [31:0] reg_rdata_i = '0;
    logic        reg_ack_i = 1'b0;
    logic        trial_req_o;
    logic        trial_done_i = 1'b0;
    logic        trial_pass_i = 1'b0;

    always #5 clk = ~clk;

    phase_tune_ctrl #(.SETTLE_CYCLES(SETTLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .busy_o(busy_o), .done_o(done_o), .error_o(error_o), .phase_o(phase_o),
        .reg_req_o(reg_req_o), .reg_we_o(reg_we_o), .reg_sel_o(reg_sel_o),
        .reg_wdata_o(reg_wdata_o), .reg_rdata_i(reg_rdata_i), .reg_ack_i(reg_ack_i),
        .trial_req_o(trial_req_o), .trial_done_i(trial_done_i), .trial_pass_i(trial_pass_i)
    );

    int n_checks = 0;
    int n_errs = 0;
    int cyc = 0;
    int exp_q[$];
    logic [31:0] pass_map = '0;
    logic [31:0] ctrl_model = CTRL_INIT;
    int last_wr_cyc = 0;
    int tr_cnt = 0;
    logic tr_pass = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input logic ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    // event codes: 64+p control write of phase p, 128 clear, 192+p trial at phase p
    task automatic observe(input int code, input string tag);
        if (exp_q.size() == 0) begin
            check(1'b0, tag, code, -1);
        end else begin
            int e;
            e = exp_q.pop_front();
            check(code == e, tag, code, e);
        end
    endtask

    // responder and monitor
    initial begin
        forever begin
            @(negedge clk);
            if (reg_ack_i) begin
                reg_ack_i = 1'b0;
            end else if (reg_req_o) begin
                if (reg_we_o && !reg_sel_o) begin
                    observe(64 + int'(reg_wdata_o[20:16]), "R2 control write phase");
                    check((reg_wdata_o & ~FIELD_MASK) == (CTRL_INIT & ~FIELD_MASK),
                          "R2 other bits kept", int'(reg_wdata_o), int'(CTRL_INIT));
                    ctrl_model  = reg_wdata_o;
                    last_wr_cyc = cyc;
                end else if (reg_we_o && reg_sel_o) begin
                    observe(128, "R4 clear order");
                    check(reg_wdata_o == 32'h0001_FFFF, "R4 clear value",
                          int'(reg_wdata_o), 32'h1FFFF);
                    check(cyc - last_wr_cyc >= SETTLE + 1, "R3 settle gap",
                          cyc - last_wr_cyc, SETTLE + 1);
                end
                reg_rdata_i = ctrl_model;
                reg_ack_i   = 1'b1;
            end
            if (trial_done_i) begin
                trial_done_i = 1'b0;
            end else if (tr_cnt > 0) begin
                tr_cnt--;
                if (tr_cnt == 0) begin
                    trial_done_i = 1'b1;
                    trial_pass_i = tr_pass;
                end
            end
            if (trial_req_o) begin
                observe(192 + int'(ctrl_model[20:16]), "R4 trial order");
                tr_pass = pass_map[ctrl_model[20:16]];
                tr_cnt  = TRIAL_LAT;
            end
        end
    end

    // driver: computes the expected sequence and result from the requirements
    task automatic push_expected(input logic [31:0] m, output int res, output logic err);
        int s, e;
        logic have, closed;
        have = 1'b0; closed = 1'b0; s = 0; e = 0;
        for (int p = 0; p < 32; p++) begin
            exp_q.push_back(64 + p);
            exp_q.push_back(128);
            exp_q.push_back(192 + p);
            if (m[p] && !have) begin
                have = 1'b1; s = p;
            end else if (!m[p] && have) begin
                e = p - 1; closed = 1'b1;
                break;
            end
        end
        if (have && !closed) e = 31;
        res = have ? (s + e) / 2 : 0;
        err = !have;
        exp_q.push_back(64 + res);
        exp_q.push_back(128);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    endtask

    task automatic run_case(input logic [31:0] m, input string name, input logic extra_start);
        int res;
        logic err;
        int t0;
        pass_map = m;
        ctrl_model = CTRL_INIT;
        push_expected(m, res, err);
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, {"R10 busy after start ", name}, busy_o, 1);
        check(done_o == 1'b0, {"R9 done cleared by start ", name}, done_o, 0);
        if (extra_start) begin
            repeat (60) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        t0 = cyc;
        while (!done_o && (cyc - t0) < 5000) @(negedge clk);
        if (!done_o) begin
            check(1'b0, {"watchdog ", name}, cyc - t0, 5000);
            finish_run();
        end
        check(busy_o == 1'b0, {"R10 busy falls with done ", name}, busy_o, 0);
        check(error_o == err, {"R7 R8 error flag ", name}, error_o, err);
        check(int'(phase_o) == res, {"R5 R6 R7 chosen phase ", name}, phase_o, res);
        check(int'(ctrl_model[20:16]) == res, {"R7 phase programmed ", name},
              ctrl_model[20:16], res);
        check(exp_q.size() == 0, {"R5 sweep length ", name}, exp_q.size(), 0);
        exp_q.delete();
        repeat (20) @(negedge clk);
        check(done_o && (error_o == err) && (int'(phase_o) == res),
              {"R9 result held ", name}, {done_o, error_o, phase_o}, {1'b1, err, res[4:0]});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && !error_o, "R1 reset flags", {busy_o, done_o, error_o}, 0);
        check(phase_o == '0, "R1 reset phase", phase_o, 0);
        check(!reg_req_o && !trial_req_o, "R1 reset requests", {reg_req_o, trial_req_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy_o && !reg_req_o, "R1 idle after reset", {busy_o, reg_req_o}, 0);

        run_case(32'h0000_1FE0, "mid window 5..12", 1'b0);     // R5 -> 8
        run_case(32'hFFF0_0000, "open to top 20..31", 1'b0);   // R6 -> 25
        run_case(32'h0000_0000, "no pass", 1'b0);              // R8 -> 0, err
        run_case(32'h8000_0000, "pass only at 31", 1'b0);      // R6 -> 31
        run_case(32'hFFFF_FFFF, "all pass", 1'b0);             // R6 -> 15
        run_case(32'h001F_FC18, "two regions", 1'b0);          // R5 -> 3
        run_case(32'h0000_01C0, "start while busy", 1'b1);     // R9 -> 7
        finish_run();
    end

    initial begin
        #1_500_000;
        check(1'b0, "watchdog global", cyc, 0);
        finish_run();
    end
endmodule